// File: doc/BRIEF.md
# Ingress Traffic Regulator

This block sits between one bus master and the interconnect and decides, cycle by cycle, whether that master's next request may pass. It combines three throttles. The first is a ceiling on transactions in flight. The second is a minimum number of cycles between two accepted requests. The third is a token bucket that bounds long-run bandwidth. A request is passed downstream only when all three agree, and the upstream ready is gated the same way, so the handshake stays consistent on both sides.

The block also watches the service the master receives. Each completion pulse carries a measured latency, which feeds a running average. Completions are also counted over a programmable window of cycles. At the end of every window the block compares achieved bandwidth and average latency against targets. While either target is missed, the outgoing QoS value climbs by one per window. Once both targets are met again, it drops back to the programmed base value.

Top module: `ingress_regulator`

## Requirements
- R1: `fwd_valid_o` equals `req_valid_i` AND permit, and `req_ready_o` equals `fwd_ready_i` AND permit. A transfer happens when `req_valid_i`, `fwd_ready_i` and permit are all high in the same cycle. Permit is the AND of the three conditions in R2, R3 and R4.
- R2: The outstanding count rises by one on each transfer and falls by one on each completion. A completion that arrives while the count is zero is ignored entirely; it has no effect on the count, the average or the window tally. The R2 condition for permit is that the count is less than `cfg_max_ost_i`.
- R3: The R3 condition for permit is that at least `cfg_min_gap_i` cycles have passed since the last transfer. A value of 0 or 1 allows back-to-back transfers.
- R4: The bucket is held in units of 1/16 token and starts empty after reset. Every cycle it gains `cfg_tok_rate_i` units, after subtracting 16 units for a transfer in that cycle. The result is clamped to `cfg_tok_cap_i`×16 units. The R4 condition for permit is that the bucket holds at least 16 units.
- R5: An accepted completion updates a scaled accumulator A as A ← A − ⌊A/8⌋ + latency. The average latency is ⌊A/8⌋.
- R6: A window closes in the cycle where the window counter plus one is at least `cfg_win_len_i`. The bandwidth test uses the accepted completions of the window, including the closing cycle. It misses when that count is below `cfg_bw_target_i`.
- R7: When a window closes with a miss (low bandwidth, or average latency above `cfg_lat_target_i`), QoS becomes one more than its current value, saturating at 15.
- R8: When a window closes with both targets met, `qos_o` returns to `cfg_qos_base_i`. Between window closes, the escalation state does not change.
- R9: During reset, `fwd_valid_o` and `req_ready_o` are low and `qos_o` equals `cfg_qos_base_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cfg_max_ost_i | input | 4 | Outstanding-transaction ceiling |
| cfg_min_gap_i | input | 8 | Minimum cycles between transfers |
| cfg_tok_rate_i | input | 8 | Bucket refill per cycle, 1/16-token units |
| cfg_tok_cap_i | input | 6 | Bucket capacity in whole tokens |
| cfg_win_len_i | input | 8 | Evaluation window length in cycles |
| cfg_bw_target_i | input | 8 | Minimum completions per window |
| cfg_lat_target_i | input | 10 | Maximum acceptable average latency |
| cfg_qos_base_i | input | 4 | QoS value when service is adequate |
| req_valid_i | input | 1 | Request valid from the master |
| req_ready_o | output | 1 | Gated ready towards the master |
| fwd_valid_o | output | 1 | Gated valid towards the interconnect |
| fwd_ready_i | input | 1 | Ready from the interconnect |
| cpl_i | input | 1 | Completion pulse |
| cpl_lat_i | input | 10 | Latency carried by the completion |
| qos_o | output | 4 | QoS value for outgoing requests |

## Verification
The bench targets five behaviours:

- **Outstanding ceiling.** It holds the ceiling at two with a long return delay. A gate whose count is off by one would let a third request through.
- **Spacing and bucket.** It stalls the downstream ready at irregular points against a spacing of five and a slow fractional refill. A counter that restarts on a stalled offer, or a bucket that forgets the fractional remainder, drifts from the reference within a few transfers.
- **Latency escalation.** It drives a long return latency until QoS should pin at 15. A missing saturation would wrap QoS back towards zero.
- **Bandwidth escalation.** It sets an unreachable bandwidth target, which should also pin QoS at 15.
- **Stray completions.** It sends completions into an empty pipeline and then confirms that a ceiling of one still admits the next request. A design that let the count go negative would wrap it and block.

// File: rtl/regu_pkg.sv
package regu_pkg;
  localparam int QOS_W   = 4;
  localparam int FRAC_W  = 4;
  localparam int TOK_ONE = 1 << FRAC_W;
  typedef logic [QOS_W-1:0] qos_t;
  localparam qos_t QOS_TOP = '1;
endpackage

// File: rtl/regu_issue_gate.sv
module regu_issue_gate #(
  parameter int OST_W = 4,
  parameter int GAP_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [OST_W-1:0] cfg_max_ost_i,
  input  logic [GAP_W-1:0] cfg_min_gap_i,
  input  logic             fire_i,
  input  logic             cpl_i,
  output logic             ost_ok_o,
  output logic             gap_ok_o,
  output logic             cpl_ok_o
);
  logic [OST_W-1:0] ost_q;
  logic [GAP_W-1:0] gap_q;

  assign cpl_ok_o = cpl_i && (ost_q != '0);
  assign ost_ok_o = ost_q < cfg_max_ost_i;
  assign gap_ok_o = gap_q >= cfg_min_gap_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ost_q <= '0;
    end else begin
      case ({fire_i, cpl_ok_o})
        2'b10:   ost_q <= ost_q + OST_W'(1);
        2'b01:   ost_q <= ost_q - OST_W'(1);
        default: ost_q <= ost_q;
      endcase
    end
  end

  // gap_q counts cycles since the last transfer, saturating; reset as "long ago"
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       gap_q <= '1;
    else if (fire_i)   gap_q <= GAP_W'(1);
    else if (!(&gap_q)) gap_q <= gap_q + GAP_W'(1);
  end

  // R2
  ost_cap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire_i |-> ost_q < cfg_max_ost_i);
  // R2
  ost_spur_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cpl_i && ost_q == '0 && !fire_i) |=> ost_q == '0);
  // R3
  gap_space_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire_i |=> (!fire_i || cfg_min_gap_i <= GAP_W'(1)));
endmodule

// File: rtl/regu_token_bucket.sv
module regu_token_bucket
  import regu_pkg::*;
#(
  parameter int TOK_W  = 6,
  parameter int RATE_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [RATE_W-1:0] cfg_rate_i,
  input  logic [TOK_W-1:0]  cfg_cap_i,
  input  logic              fire_i,
  output logic              tok_ok_o
);
  localparam int BKT_W = ((TOK_W + FRAC_W) > RATE_W ? (TOK_W + FRAC_W) : RATE_W) + 2;

  logic [BKT_W-1:0] tok_q, cap_u, after_use, refill;

  assign cap_u     = BKT_W'(cfg_cap_i) << FRAC_W;
  assign after_use = fire_i ? tok_q - BKT_W'(TOK_ONE) : tok_q;
  assign refill    = after_use + BKT_W'(cfg_rate_i);
  assign tok_ok_o  = tok_q >= BKT_W'(TOK_ONE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) tok_q <= '0;
    else         tok_q <= (refill > cap_u) ? cap_u : refill;
  end

  // R4
  tok_cover_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire_i |-> tok_q >= BKT_W'(TOK_ONE));
endmodule

// File: rtl/regu_service_mon.sv
module regu_service_mon
  import regu_pkg::*;
#(
  parameter int LAT_W = 10,
  parameter int WIN_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cpl_ok_i,
  input  logic [LAT_W-1:0] cpl_lat_i,
  input  logic [WIN_W-1:0] cfg_win_len_i,
  input  logic [WIN_W-1:0] cfg_bw_target_i,
  input  logic [LAT_W-1:0] cfg_lat_target_i,
  input  qos_t             cfg_qos_base_i,
  output qos_t             qos_o
);
  localparam int ACC_W = LAT_W + 3;
  localparam logic [WIN_W:0] W_ONE = 1;

  logic [ACC_W-1:0] acc_q;
  logic [LAT_W-1:0] avg;
  logic [WIN_W-1:0] win_q, bw_q;
  logic [WIN_W:0]   bw_eff;
  logic             win_end, miss, act_q;
  qos_t             q_q, start, bumped;

  // acc_q holds 8x the average
  assign avg     = acc_q[ACC_W-1:3];
  assign win_end = ({1'b0, win_q} + W_ONE) >= {1'b0, cfg_win_len_i};
  assign bw_eff  = {1'b0, bw_q} + {{WIN_W{1'b0}}, cpl_ok_i};
  assign miss    = (bw_eff < {1'b0, cfg_bw_target_i}) || (avg > cfg_lat_target_i);
  assign start   = act_q ? q_q : cfg_qos_base_i;
  assign bumped  = (start == QOS_TOP) ? start : start + qos_t'(1);
  assign qos_o   = act_q ? q_q : cfg_qos_base_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       acc_q <= '0;
    else if (cpl_ok_i) acc_q <= acc_q - (acc_q >> 3) + ACC_W'(cpl_lat_i);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      win_q <= '0;
      bw_q  <= '0;
    end else if (win_end) begin
      win_q <= '0;
      bw_q  <= '0;
    end else begin
      win_q <= win_q + WIN_W'(1);
      bw_q  <= bw_eff[WIN_W] ? '1 : bw_eff[WIN_W-1:0];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q <= 1'b0;
      q_q   <= '0;
    end else if (win_end) begin
      if (miss) begin
        act_q <= 1'b1;
        q_q   <= bumped;
      end else begin
        act_q <= 1'b0;
      end
    end
  end

  // R5
  ema_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cpl_ok_i |=> $stable(acc_q));
  // R8
  qos_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !win_end |=> ($stable(act_q) && $stable(q_q)));
endmodule

// File: rtl/ingress_regulator.sv
module ingress_regulator
  import regu_pkg::*;
#(
  parameter int OST_W  = 4,
  parameter int GAP_W  = 8,
  parameter int TOK_W  = 6,
  parameter int RATE_W = 8,
  parameter int LAT_W  = 10,
  parameter int WIN_W  = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [OST_W-1:0]  cfg_max_ost_i,
  input  logic [GAP_W-1:0]  cfg_min_gap_i,
  input  logic [RATE_W-1:0] cfg_tok_rate_i,
  input  logic [TOK_W-1:0]  cfg_tok_cap_i,
  input  logic [WIN_W-1:0]  cfg_win_len_i,
  input  logic [WIN_W-1:0]  cfg_bw_target_i,
  input  logic [LAT_W-1:0]  cfg_lat_target_i,
  input  logic [3:0]        cfg_qos_base_i,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  output logic              fwd_valid_o,
  input  logic              fwd_ready_i,
  input  logic              cpl_i,
  input  logic [LAT_W-1:0]  cpl_lat_i,
  output logic [3:0]        qos_o
);
  logic ost_ok, gap_ok, tok_ok, cpl_ok, permit, fire;
  qos_t qos;

  assign permit      = ost_ok && gap_ok && tok_ok;
  assign fwd_valid_o = req_valid_i && permit;
  assign req_ready_o = fwd_ready_i && permit;
  assign fire        = req_valid_i && fwd_ready_i && permit;
  assign qos_o       = qos;

  regu_issue_gate #(.OST_W(OST_W), .GAP_W(GAP_W)) u_gate (
    .clk_i, .rst_ni,
    .cfg_max_ost_i, .cfg_min_gap_i,
    .fire_i   (fire),
    .cpl_i,
    .ost_ok_o (ost_ok),
    .gap_ok_o (gap_ok),
    .cpl_ok_o (cpl_ok)
  );

  regu_token_bucket #(.TOK_W(TOK_W), .RATE_W(RATE_W)) u_bucket (
    .clk_i, .rst_ni,
    .cfg_rate_i (cfg_tok_rate_i),
    .cfg_cap_i  (cfg_tok_cap_i),
    .fire_i     (fire),
    .tok_ok_o   (tok_ok)
  );

  regu_service_mon #(.LAT_W(LAT_W), .WIN_W(WIN_W)) u_mon (
    .clk_i, .rst_ni,
    .cpl_ok_i (cpl_ok),
    .cpl_lat_i,
    .cfg_win_len_i, .cfg_bw_target_i, .cfg_lat_target_i,
    .cfg_qos_base_i (qos_t'(cfg_qos_base_i)),
    .qos_o          (qos)
  );

  // R1
  fwd_pair_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fwd_valid_o && fwd_ready_i) |-> req_ready_o);
endmodule

// File: tb/ingress_regulator_test.sv
module ingress_regulator_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic [3:0] cfg_max_ost;
  logic [7:0] cfg_min_gap, cfg_tok_rate, cfg_win_len, cfg_bw_target;
  logic [5:0] cfg_tok_cap;
  logic [9:0] cfg_lat_target, cpl_lat;
  logic [3:0] cfg_qos_base;
  logic req_valid, req_ready, fwd_valid, fwd_ready, cpl;
  logic [3:0] qos;

  ingress_regulator uut (
    .clk_i(clk), .rst_ni(rst_n),
    .cfg_max_ost_i(cfg_max_ost), .cfg_min_gap_i(cfg_min_gap),
    .cfg_tok_rate_i(cfg_tok_rate), .cfg_tok_cap_i(cfg_tok_cap),
    .cfg_win_len_i(cfg_win_len), .cfg_bw_target_i(cfg_bw_target),
    .cfg_lat_target_i(cfg_lat_target), .cfg_qos_base_i(cfg_qos_base),
    .req_valid_i(req_valid), .req_ready_o(req_ready),
    .fwd_valid_o(fwd_valid), .fwd_ready_i(fwd_ready),
    .cpl_i(cpl), .cpl_lat_i(cpl_lat), .qos_o(qos)
  );

  int total = 0, bad = 0;
  bit done = 0;
  string tag = "R9";
  int m_ost, m_gap, m_tok, m_acc, m_win, m_bw, m_q, m_act;
  int cyc = 0, dly = 10, rv_mode = 0, fr_mode = 0, last_x = -1000;
  bit spur = 0;
  int iss_q[$];

  task automatic check(input string req, input int act, input int exp, input string what);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d (cycle %0d)", req, what, act, exp, cyc);
    end
  endtask

  task automatic step();
    int permit, fire, cok, ev, bwe, avg, st, e_q, l;
    cyc++;
    req_valid = (rv_mode < 0) ? 1'b0 : (rv_mode == 0) ? 1'b1 : ((cyc % rv_mode) != 0);
    fwd_ready = (fr_mode == 0) ? 1'b1 : ((cyc % fr_mode) != 0);
    if (spur) begin
      cpl = 1'b1; cpl_lat = 10'd7;
    end else if (iss_q.size() > 0 && cyc - iss_q[0] >= dly) begin
      l = cyc - iss_q[0];
      cpl = 1'b1; cpl_lat = 10'(l > 1023 ? 1023 : l);
    end else begin
      cpl = 1'b0; cpl_lat = 10'd0;
    end
    #1;
    permit = (m_ost < int'(cfg_max_ost)) && (m_gap >= int'(cfg_min_gap)) && (m_tok >= 16);
    fire   = req_valid && fwd_ready && permit;
    e_q    = m_act ? m_q : int'(cfg_qos_base);
    check(tag, int'(fwd_valid), int'(req_valid) & permit, "fwd_valid");
    check(tag, int'(req_ready), int'(fwd_ready) & permit, "req_ready");
    check(tag, int'(qos), e_q, "qos");
    if (fwd_valid && fwd_ready) begin
      // R3: spacing observed at the ports
      if (cfg_min_gap > 1) check("R3", int'(cyc - last_x >= int'(cfg_min_gap)), 1, "spacing");
      last_x = cyc;
    end
    @(posedge clk);
    cok = cpl && (m_ost > 0);
    ev  = (m_win + 1 >= int'(cfg_win_len));
    bwe = m_bw + cok;
    avg = m_acc / 8;
    if (ev) begin
      if (bwe < int'(cfg_bw_target) || avg > int'(cfg_lat_target)) begin
        st = m_act ? m_q : int'(cfg_qos_base);
        m_q = (st >= 15) ? 15 : st + 1;
        m_act = 1;
      end else m_act = 0;
      m_win = 0; m_bw = 0;
    end else begin
      m_win++;
      m_bw = (bwe > 255) ? 255 : bwe;
    end
    if (cok) m_acc = m_acc - m_acc / 8 + int'(cpl_lat);
    m_ost = m_ost + fire - cok;
    m_gap = fire ? 1 : ((m_gap >= 255) ? 255 : m_gap + 1);
    m_tok = m_tok - (fire ? 16 : 0) + int'(cfg_tok_rate);
    if (m_tok > int'(cfg_tok_cap) * 16) m_tok = int'(cfg_tok_cap) * 16;
    if (cok && iss_q.size() > 0) void'(iss_q.pop_front());
    if (fire) iss_q.push_back(cyc);
    @(negedge clk);
  endtask

  task automatic run(input int n);
    for (int i = 0; i < n; i++) begin
      step();
      // R2: bench-side in-flight count never exceeds the ceiling
      if (iss_q.size() > int'(cfg_max_ost)) check("R2", iss_q.size(), int'(cfg_max_ost), "inflight");
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    cfg_max_ost = 4'd2; cfg_min_gap = 8'd0; cfg_tok_rate = 8'd255; cfg_tok_cap = 6'd8;
    cfg_win_len = 8'd16; cfg_bw_target = 8'd0; cfg_lat_target = 10'd1023; cfg_qos_base = 4'd2;
    req_valid = 1'b1; fwd_ready = 1'b1; cpl = 1'b0; cpl_lat = 10'd0;
    m_ost = 0; m_gap = 255; m_tok = 0; m_acc = 0; m_win = 0; m_bw = 0; m_q = 0; m_act = 0;
    repeat (3) @(negedge clk);
    #1;
    check("R9", int'(fwd_valid), 0, "reset fwd_valid");
    check("R9", int'(req_ready), 0, "reset req_ready");
    check("R9", int'(qos), 2, "reset qos");
    @(negedge clk);
    rst_n = 1'b1;

    tag = "R1"; dly = 12; run(60);
    tag = "R2"; run(90);
    tag = "R3"; cfg_max_ost = 4'd15; cfg_min_gap = 8'd5; dly = 3; rv_mode = 4; fr_mode = 3; run(150);
    tag = "R4"; cfg_min_gap = 8'd0; cfg_tok_rate = 8'd4; cfg_tok_cap = 6'd2; rv_mode = 0; fr_mode = 0; run(200);

    tag = "R5"; cfg_tok_rate = 8'd255; cfg_tok_cap = 6'd8; dly = 40; cfg_lat_target = 10'd10; run(200);
    tag = "R7"; run(300);
    check("R7", int'(qos), 15, "qos saturated on latency miss");
    tag = "R8"; cfg_lat_target = 10'd1023; run(40);
    check("R8", int'(qos), 2, "qos back to base");

    tag = "R6"; cfg_bw_target = 8'd200; run(300);
    check("R6", int'(qos), 15, "qos saturated on bandwidth miss");
    cfg_bw_target = 8'd0; run(40);
    check("R8", int'(qos), 2, "qos back to base after bandwidth");

    tag = "R2"; rv_mode = -1; run(80);
    check("R2", iss_q.size(), 0, "drained");
    spur = 1'b1; run(3); spur = 1'b0;
    cfg_max_ost = 4'd1; rv_mode = 0;
    step();
    check("R2", int'(last_x == cyc), 1, "admitted after stray completions");
    run(50);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule